// File: doc/BRIEF.md
# I3C Test Target Loopback Backend

This block is the transaction layer of an I3C test target. It sits behind a bus front end that has already decoded the serial traffic. The front end hands the block three kinds of transfer: private write bytes, private read requests, and common command codes (CCCs) tagged as broadcast or directed. Bytes that the controller writes are kept in an internal byte queue. On a read, the block returns either the oldest queued byte with every bit flipped, or a fixed fallback byte. Which of the two it returns depends on a build-time loopback switch and on whether the queue holds data.

The block also keeps the target's dynamic address. A broadcast ENTDAA opens an assignment window. The front end runs the arbitration using the 64-bit word the block presents, and then strobes in the address it won. A broadcast RSTDAA drops the address. Directed GET commands for the maximum write and read lengths, the provisional ID, the bus characteristics and the device characteristics load a small response engine. That engine appends the answer bytes to the same queue, so the controller fetches them with ordinary private reads.

Top module: `i3c_loop_target`

## Requirements
- R1: While a dynamic address is assigned, each private write byte is appended to a queue of DEPTH bytes (default 2048), and the bytes are kept in arrival order.
- R2: With INV_LOOPBACK=1 and the queue not empty, a read request produces rd_valid_o one cycle later. rd_data_o then holds the bitwise NOT of the oldest queued byte, and that byte is removed from the queue.
- R3: With INV_LOOPBACK=1 and the queue empty, a read returns FALLBACK (default 8'hA5).
- R4: With INV_LOOPBACK=0 (the default), every read returns FALLBACK and removes nothing from the queue.
- R5: A write that arrives while the queue is full is discarded and sets overflow_o. overflow_o stays set until reset.
- R6: While no dynamic address is assigned, private writes are not stored and read requests give no rd_valid_o.
- R7: A broadcast ENTDAA (code 8'h07, ccc_direct_i=0) opens the assignment window. An asg_valid_i strobe inside that window latches the 7-bit asg_addr_i, sets addr_valid_o and closes the window. A strobe outside the window, or one that arrives while an address is already held, is ignored.
- R8: A broadcast RSTDAA (code 8'h06, ccc_direct_i=0) clears the dynamic address and addr_valid_o.
- R9: A directed GETMWL (8'h8B) or GETMRL (8'h8C) queues DEPTH as a 16-bit value, high byte first.
- R10: A directed GETPID (8'h8D) queues the low 48 bits of the 64-bit PID parameter as six bytes, high byte first.
- R11: A directed GETBCR (8'h8E) queues the BCR byte, and a directed GETDCR (8'h8F) queues the DCR byte.
- R12: Response bytes are queued one per cycle, starting on the cycle after the command. ccc_busy_o is high for exactly as many cycles as there are bytes. A directed command with any other code, and any directed command received while unassigned, queues nothing.
- R13: arb_word_o presents {PID[47:0], BCR, DCR} for use in dynamic address arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Private write byte strobe |
| wr_data_i | input | 8 | Private write byte |
| rd_req_i | input | 1 | Private read request |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 8 | Read data byte |
| ccc_valid_i | input | 1 | Command code strobe |
| ccc_code_i | input | 8 | Command code |
| ccc_direct_i | input | 1 | 1 for a directed command, 0 for a broadcast command |
| asg_valid_i | input | 1 | Strobe carrying the address won in arbitration |
| asg_addr_i | input | 7 | Address won in arbitration |
| addr_valid_o | output | 1 | A dynamic address is held |
| dyn_addr_o | output | 7 | Current dynamic address |
| ccc_busy_o | output | 1 | Response engine is queuing bytes |
| overflow_o | output | 1 | Sticky flag: a write was lost to a full queue |
| arb_word_o | output | 64 | Arbitration word {PID, BCR, DCR} |

## Verification
The assertions assume that the front end sends no private write and no new command code while ccc_busy_o is high. The queue has a single push port, which the response engine owns during those cycles. The stimulus keeps to this by polling ccc_busy_o after each command until it falls, and only then issuing the next transfer. The assertions also assume that a pop happens only when the queue holds data and that an address is taken only inside an open ENTDAA window. The stimulus checks both of these from the outside: it issues assignments with and without a preceding ENTDAA, and it reads both a filled queue and an empty one.

// File: rtl/i3c_loop_pkg.sv
package i3c_loop_pkg;

    localparam logic [7:0] CMD_RSTDAA = 8'h06;
    localparam logic [7:0] CMD_ENTDAA = 8'h07;
    localparam logic [7:0] CMD_GETMWL = 8'h8B;
    localparam logic [7:0] CMD_GETMRL = 8'h8C;
    localparam logic [7:0] CMD_GETPID = 8'h8D;
    localparam logic [7:0] CMD_GETBCR = 8'h8E;
    localparam logic [7:0] CMD_GETDCR = 8'h8F;

    localparam int RESP_BYTES = 6;

    // Response bytes, left-aligned, sent from the top byte down.
    typedef struct packed {
        logic [8*RESP_BYTES-1:0] bytes;
        logic [2:0]              len;
    } resp_t;

    function automatic resp_t build_resp(input logic [7:0]  code,
                                         input logic [15:0] depth_w,
                                         input logic [47:0] pid48,
                                         input logic [7:0]  bcr,
                                         input logic [7:0]  dcr);
        resp_t r;
        r.bytes = '0;
        r.len   = 3'd0;
        case (code)
            CMD_GETMWL, CMD_GETMRL: begin r.bytes = {depth_w, 32'h0}; r.len = 3'd2; end
            CMD_GETPID:             begin r.bytes = pid48;            r.len = 3'd6; end
            CMD_GETBCR:             begin r.bytes = {bcr, 40'h0};     r.len = 3'd1; end
            CMD_GETDCR:             begin r.bytes = {dcr, 40'h0};     r.len = 3'd1; end
            default:                begin r.bytes = '0;               r.len = 3'd0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i3c_loop_fifo.sv
module i3c_loop_fifo #(
    parameter int DEPTH = 2048,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty_o = (count == '0);
    assign full_o  = (count == CW'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign dout_o  = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o && !pop_i) |=> full_o); // R5

endmodule

// File: rtl/i3c_loop_ccc.sv
module i3c_loop_ccc
    import i3c_loop_pkg::*;
#(
    parameter int          DEPTH = 2048,
    parameter logic [63:0] PID   = 64'h0000_FB11_2233_0001,
    parameter logic [7:0]  BCR   = 8'h26,
    parameter logic [7:0]  DCR   = 8'hE1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ccc_valid_i,
    input  logic [7:0] ccc_code_i,
    input  logic       ccc_direct_i,
    input  logic       assigned_i,
    output logic       push_o,
    output logic [7:0] byte_o,
    output logic       busy_o,
    output logic       rstdaa_o,
    output logic       entdaa_o
);
    localparam logic [15:0] DEPTH_W = 16'(DEPTH);
    localparam logic [47:0] PID48   = PID[47:0];

    logic [8*RESP_BYTES-1:0] sh_q;
    logic [2:0]              left_q;
    resp_t                   resp;

    always_comb resp = build_resp(ccc_code_i, DEPTH_W, PID48, BCR, DCR);

    assign busy_o   = (left_q != 3'd0);
    assign push_o   = busy_o;
    assign byte_o   = sh_q[8*RESP_BYTES-1 -: 8];
    assign rstdaa_o = ccc_valid_i && !ccc_direct_i && (ccc_code_i == CMD_RSTDAA);
    assign entdaa_o = ccc_valid_i && !ccc_direct_i && (ccc_code_i == CMD_ENTDAA);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (busy_o) begin
            sh_q   <= sh_q << 8;
            left_q <= left_q - 3'd1;
        end else if (ccc_valid_i && ccc_direct_i && assigned_i) begin
            sh_q   <= resp.bytes;
            left_q <= resp.len;
        end
    end

    AST_BUSY_NO_NEW_CMD: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !ccc_valid_i); // R12
    AST_BUSY_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(assigned_i)); // R12

endmodule

// File: rtl/i3c_loop_addr.sv
module i3c_loop_addr (
    input  logic       clk,
    input  logic       rst,
    input  logic       rstdaa_i,
    input  logic       entdaa_i,
    input  logic       asg_valid_i,
    input  logic [6:0] asg_addr_i,
    output logic       assigned_o,
    output logic [6:0] addr_o
);
    logic daa_open_q;

    always_ff @(posedge clk) begin
        if (rst || rstdaa_i) begin
            assigned_o <= 1'b0;
            addr_o     <= '0;
            daa_open_q <= 1'b0;
        end else if (entdaa_i && !assigned_o) begin
            daa_open_q <= 1'b1;
        end else if (asg_valid_i && daa_open_q && !assigned_o) begin
            addr_o     <= asg_addr_i;
            assigned_o <= 1'b1;
            daa_open_q <= 1'b0;
        end
    end

    AST_ASSIGN_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(assigned_o) |-> $past(daa_open_q && asg_valid_i)); // R7
    AST_RSTDAA_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rstdaa_i |=> !assigned_o); // R8

endmodule

// File: rtl/i3c_loop_target.sv
module i3c_loop_target
    import i3c_loop_pkg::*;
#(
    parameter int          DEPTH        = 2048,
    parameter bit          INV_LOOPBACK = 1'b0,
    parameter logic [7:0]  FALLBACK     = 8'hA5,
    parameter logic [63:0] PID          = 64'h0000_FB11_2233_0001,
    parameter logic [7:0]  BCR          = 8'h26,
    parameter logic [7:0]  DCR          = 8'hE1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid_i,
    input  logic [7:0]  wr_data_i,
    input  logic        rd_req_i,
    output logic        rd_valid_o,
    output logic [7:0]  rd_data_o,
    input  logic        ccc_valid_i,
    input  logic [7:0]  ccc_code_i,
    input  logic        ccc_direct_i,
    input  logic        asg_valid_i,
    input  logic [6:0]  asg_addr_i,
    output logic        addr_valid_o,
    output logic [6:0]  dyn_addr_o,
    output logic        ccc_busy_o,
    output logic        overflow_o,
    output logic [63:0] arb_word_o
);
    logic       assigned, rstdaa, entdaa;
    logic       gen_push;
    logic [7:0] gen_byte;
    logic       q_push, q_pop, q_empty, q_full;
    logic [7:0] q_din, q_head;

    assign arb_word_o   = {PID[47:0], BCR, DCR};
    assign addr_valid_o = assigned;

    i3c_loop_addr u_addr (
        .clk(clk), .rst(rst), .rstdaa_i(rstdaa), .entdaa_i(entdaa),
        .asg_valid_i(asg_valid_i), .asg_addr_i(asg_addr_i),
        .assigned_o(assigned), .addr_o(dyn_addr_o)
    );

    i3c_loop_ccc #(.DEPTH(DEPTH), .PID(PID), .BCR(BCR), .DCR(DCR)) u_ccc (
        .clk(clk), .rst(rst), .ccc_valid_i(ccc_valid_i), .ccc_code_i(ccc_code_i),
        .ccc_direct_i(ccc_direct_i), .assigned_i(assigned),
        .push_o(gen_push), .byte_o(gen_byte), .busy_o(ccc_busy_o),
        .rstdaa_o(rstdaa), .entdaa_o(entdaa)
    );

    // The response engine owns the push port while it is busy.
    assign q_push = gen_push || (wr_valid_i && assigned && !ccc_busy_o);
    assign q_din  = ccc_busy_o ? gen_byte : wr_data_i;

    generate
        if (INV_LOOPBACK) begin : g_inv
            assign q_pop = rd_req_i && assigned && !q_empty;
        end else begin : g_plain
            assign q_pop = 1'b0;
        end
    endgenerate

    i3c_loop_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst(rst), .push_i(q_push), .din_i(q_din), .pop_i(q_pop),
        .dout_o(q_head), .empty_o(q_empty), .full_o(q_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            overflow_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_req_i && assigned;
            if (rd_req_i && assigned)
                rd_data_o <= q_pop ? ~q_head : FALLBACK;
            if (q_push && q_full)
                overflow_o <= 1'b1;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o); // R5
    AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> $past(rd_req_i && assigned)); // R6
    AST_NO_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        ccc_busy_o |-> !wr_valid_i); // R12

endmodule

// File: tb/test_i3c_loop_target.sv
`timescale 1ns/1ps
module test_i3c_loop_target;
    localparam int          DEPTH = 2048;
    localparam logic [63:0] PID   = 64'hDEAD_FB11_2233_0001;
    localparam logic [7:0]  BCR   = 8'h26;
    localparam logic [7:0]  DCR   = 8'hC6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 0, rd_req = 0, ccc_valid = 0, ccc_direct = 0, asg_valid = 0;
    logic [7:0] wr_data = 0, ccc_code = 0;
    logic [6:0] asg_addr = 0;

    logic        rv_i, rv_p, av_i, av_p, busy_i, busy_p, ovf_i, ovf_p;
    logic [7:0]  rd_i, rd_p;
    logic [6:0]  da_i, da_p;
    logic [63:0] arb_i, arb_p;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    i3c_loop_target #(.DEPTH(DEPTH), .INV_LOOPBACK(1'b1), .PID(PID), .BCR(BCR), .DCR(DCR))
    i_i3c_loop_target (
        .clk(clk), .rst(rst), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
        .rd_req_i(rd_req), .rd_valid_o(rv_i), .rd_data_o(rd_i),
        .ccc_valid_i(ccc_valid), .ccc_code_i(ccc_code), .ccc_direct_i(ccc_direct),
        .asg_valid_i(asg_valid), .asg_addr_i(asg_addr),
        .addr_valid_o(av_i), .dyn_addr_o(da_i), .ccc_busy_o(busy_i),
        .overflow_o(ovf_i), .arb_word_o(arb_i)
    );

    i3c_loop_target #(.DEPTH(DEPTH), .PID(PID), .BCR(BCR), .DCR(DCR))
    i_i3c_loop_target_plain (
        .clk(clk), .rst(rst), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
        .rd_req_i(rd_req), .rd_valid_o(rv_p), .rd_data_o(rd_p),
        .ccc_valid_i(ccc_valid), .ccc_code_i(ccc_code), .ccc_direct_i(ccc_direct),
        .asg_valid_i(asg_valid), .asg_addr_i(asg_addr),
        .addr_valid_o(av_p), .dyn_addr_o(da_p), .ccc_busy_o(busy_p),
        .overflow_o(ovf_p), .arb_word_o(arb_p)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; wr_valid = 0; rd_req = 0; ccc_valid = 0; asg_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_valid = 1; wr_data = d;
        @(negedge clk); wr_valid = 0;
    endtask

    task automatic do_read();
        @(negedge clk); rd_req = 1;
        @(negedge clk); rd_req = 0;
    endtask

    task automatic do_cmd(input logic [7:0] code, input logic dir);
        @(negedge clk); ccc_valid = 1; ccc_code = code; ccc_direct = dir;
        @(negedge clk); ccc_valid = 0;
        while (busy_i) @(negedge clk);
    endtask

    task automatic do_assign(input logic [6:0] a);
        @(negedge clk); asg_valid = 1; asg_addr = a;
        @(negedge clk); asg_valid = 0;
    endtask

    task automatic read_expect(input string tag, input logic [7:0] exp_inv, input logic [7:0] exp_pl);
        do_read();
        chk({tag, " valid"}, rv_i, 1);
        chk({tag, " inverted data"}, rd_i, exp_inv);
        chk({tag, " plain data"}, rd_p, exp_pl);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R6 reset rd_valid", rv_i, 0);
        chk("R7 reset addr_valid", av_i, 0);
        chk("R5 reset overflow", ovf_i, 0);
        chk("R12 reset busy", busy_i, 0);
        chk("R13 arb word", arb_i, {PID[47:0], BCR, DCR});
    endtask

    task automatic t_unassigned();
        do_write(8'h11);
        do_read();
        chk("R6 no read when unassigned", rv_i, 0);
        do_assign(7'h15);
        chk("R7 assign without ENTDAA ignored", av_i, 0);
        do_cmd(8'h07, 1'b0);
        do_assign(7'h2A);
        chk("R7 assigned", av_i, 1);
        chk("R7 address", da_i, 7'h2A);
        do_cmd(8'h07, 1'b0);
        do_assign(7'h33);
        chk("R7 reassign ignored", da_i, 7'h2A);
        read_expect("R6 unassigned write not stored / R3 empty", 8'hA5, 8'hA5);
    endtask

    task automatic t_loopback();
        do_write(8'h00); do_write(8'h3C); do_write(8'hFF); do_write(8'h81);
        read_expect("R1 R2 R4 byte0", 8'hFF, 8'hA5);
        read_expect("R1 R2 R4 byte1", 8'hC3, 8'hA5);
        read_expect("R1 R2 R4 byte2", 8'h00, 8'hA5);
        read_expect("R1 R2 R4 byte3", 8'h7E, 8'hA5);
        read_expect("R3 drained", 8'hA5, 8'hA5);
    endtask

    task automatic t_get_cmds();
        int n;
        do_cmd(8'h8B, 1'b1);
        read_expect("R9 GETMWL hi", ~8'h08, 8'hA5);
        read_expect("R9 GETMWL lo", ~8'h00, 8'hA5);
        do_cmd(8'h8C, 1'b1);
        read_expect("R9 GETMRL hi", ~8'h08, 8'hA5);
        read_expect("R9 GETMRL lo", ~8'h00, 8'hA5);
        @(negedge clk); ccc_valid = 1; ccc_code = 8'h8D; ccc_direct = 1;
        @(negedge clk); ccc_valid = 0;
        n = 0;
        while (busy_i && n < 20) begin n++; @(negedge clk); end
        chk("R12 GETPID busy cycles", n, 6);
        read_expect("R10 pid0", ~8'hFB, 8'hA5);
        read_expect("R10 pid1", ~8'h11, 8'hA5);
        read_expect("R10 pid2", ~8'h22, 8'hA5);
        read_expect("R10 pid3", ~8'h33, 8'hA5);
        read_expect("R10 pid4", ~8'h00, 8'hA5);
        read_expect("R10 pid5", ~8'h01, 8'hA5);
        do_cmd(8'h8E, 1'b1);
        read_expect("R11 GETBCR", ~BCR, 8'hA5);
        do_cmd(8'h8F, 1'b1);
        read_expect("R11 GETDCR", ~DCR, 8'hA5);
        do_cmd(8'h90, 1'b1);
        read_expect("R12 unknown code queues nothing", 8'hA5, 8'hA5);
    endtask

    task automatic t_rstdaa();
        do_cmd(8'h06, 1'b0);
        chk("R8 RSTDAA clears", av_i, 0);
        do_cmd(8'h8E, 1'b1);
        chk("R12 no busy when unassigned", busy_i, 0);
        do_cmd(8'h07, 1'b0);
        do_assign(7'h10);
        chk("R7 address after RSTDAA", da_i, 7'h10);
        read_expect("R12 unassigned GET queued nothing", 8'hA5, 8'hA5);
    endtask

    task automatic t_overflow();
        do_reset();
        do_cmd(8'h07, 1'b0);
        do_assign(7'h22);
        for (int i = 0; i < DEPTH; i++) do_write(i[7:0]);
        chk("R5 no overflow at exactly full inv", ovf_i, 0);
        chk("R5 no overflow at exactly full plain", ovf_p, 0);
        read_expect("R1 full read 0", 8'hFF, 8'hA5);
        read_expect("R1 full read 1", 8'hFE, 8'hA5);
        read_expect("R1 full read 2", 8'hFD, 8'hA5);
        do_write(8'h55);
        chk("R4 plain reads did not pop", ovf_p, 1);
        chk("R5 inverted has room", ovf_i, 0);
        do_write(8'h56); do_write(8'h57);
        chk("R5 inverted exactly full", ovf_i, 0);
        do_write(8'h58);
        chk("R5 overflow set", ovf_i, 1);
        repeat (5) @(negedge clk);
        chk("R5 overflow sticky", ovf_i, 1);
        do_reset();
        chk("R5 overflow cleared by reset", ovf_i, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_unassigned();
        t_loopback();
        t_get_cmds();
        t_rstdaa();
        t_overflow();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule